// File: doc/BRIEF.md
# PCI Read Initiator

This block is the master side of read transactions on a 32-bit multiplexed address/data PCI bus. A local client presents a request holding a start address, a bus command, the byte-lane enables and a beat count. The block runs a one-clock address phase, releases the shared AD lines for the turnaround, and holds IRDY asserted through the data phases. It returns every transferred word to the client with a one-cycle valid strobe. Arbitration is assumed to be always granted. Parity, retry, disconnect and writes are not handled here.

The bus pins are modelled as active-high internal levels with separate output enables: one enable for AD and one shared by FRAME, IRDY and C/BE. Pad inversion and the tristate buffers belong to the surrounding chip. The final beat is announced only by dropping FRAME while IRDY stays asserted. A target that does not claim the cycle within the decode window ends the transaction as a master abort and raises an error flag.

Top module: `pci_rd_master`

## Requirements
- R1: In the cycle after a request is accepted, the block drives one address-phase cycle with frame_o=1, irdy_o=0, ad_oe=1, ad_o equal to the request address, cbe_o equal to the request command and ctl_oe=1.
- R2: ad_oe is 0 in every cycle other than the address phase, so the AD lines are released for the turnaround and the data phases.
- R3: From the first data-phase clock through the completion cycle, ctl_oe stays 1 and cbe_o carries the request byte enables.
- R4: A beat transfers only on a rising edge where irdy_o and trdy_i are both 1. In the following cycle, rsp_valid is 1 and rsp_data holds the ad_i value sampled at that edge. An edge where trdy_i is 0 is a wait cycle and produces no rsp_valid. trdy_i seen outside the data phases produces no rsp_valid.
- R5: During the data phases irdy_o is 1, and frame_o is 1 exactly while more than one beat remains. A single-beat read therefore negates frame_o on its first data clock. An N-beat burst keeps frame_o high until the cycle in which beat N is pending.
- R6: In the cycle after the last beat transfers, the outputs are irdy_o=0, frame_o=0, ctl_oe=1 and done=1. In the cycle after that, the block is idle with req_ready=1 and ctl_oe=0.
- R7: If devsel_i is 0 at each of the first five data-phase edges, the block aborts. It spends one cycle with frame_o=0 and irdy_o=1. It then spends one cycle with irdy_o=0, done=1 and abort_err=1. No rsp_valid is produced. devsel_i first seen at the fifth data edge avoids the abort.
- R8: While rst_n is low and after its release, the block is idle: req_ready=1, ctl_oe=0, ad_oe=0, rsp_valid=0, done=0.
- R9: A request with a beat count of 0 is carried out as a single-beat read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Local read request present |
| req_addr | input | 32 | Start address |
| req_cmd | input | 4 | Bus command for the address phase |
| req_be | input | 4 | Byte-lane enables for the data phases |
| req_beats | input | 8 | Number of beats (0 means 1) |
| req_ready | output | 1 | Block idle; request accepted when both high |
| rsp_valid | output | 1 | One returned data word |
| rsp_data | output | 32 | Returned data word |
| done | output | 1 | Transaction finished this cycle |
| abort_err | output | 1 | Finished by master abort |
| frame_o | output | 1 | FRAME level, asserted high |
| irdy_o | output | 1 | IRDY level, asserted high |
| ctl_oe | output | 1 | Drive enable for FRAME, IRDY and C/BE |
| cbe_o | output | 4 | Command or byte enables |
| ad_o | output | 32 | Address driven during the address phase |
| ad_oe | output | 1 | Drive enable for AD |
| ad_i | input | 32 | Sampled AD lines |
| trdy_i | input | 1 | TRDY level from the target, asserted high |
| devsel_i | input | 1 | DEVSEL level from the target, asserted high |

## Verification
The assertions take for granted that the target behaves legally. TRDY is assumed to rise only while DEVSEL is asserted, and never during the cycle in which the initiator is already ending an abort. Under that assumption every returned word can be traced back to a data-phase edge with both ready signals high.

The bench's target model keeps to these rules. It asserts DEVSEL after a programmable decode delay. It holds TRDY low through the turnaround clock and inserts per-beat wait cycles. It drives TRDY only spuriously in address-phase cycles, where IRDY is low.

// File: rtl/pci_rd_pkg.sv
// Shared types for the PCI read initiator.
package pci_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_DATA  = 3'd2,
        ST_FLUSH = 3'd3,
        ST_END   = 3'd4
    } rd_state_e;
endpackage

// File: rtl/pci_rd_beat_ctr.sv
// Remaining-beat counter. Loads the requested count (0 taken as 1),
// counts down once per transferred beat, and flags when one beat remains.
// Assumes load and dec are never high in the same cycle.
module pci_rd_beat_ctr #(
    parameter int BEAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BEAT_W-1:0] load_val,
    input  logic              dec,
    output logic              last
);
    localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

    logic [BEAT_W-1:0] rem_q;

    // Hold the number of beats still to transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rem_q <= '0;
        else if (load)
            rem_q <= (load_val == '0) ? ONE : load_val;
        else if (dec && rem_q != '0)
            rem_q <= rem_q - ONE;
    end

    // One beat left: the pending beat is the final one.
    always_comb last = (rem_q == ONE);
endmodule

// File: rtl/pci_rd_devsel_timer.sv
// Decode watchdog. Counts data-phase edges without DEVSEL and
// flags expiry on the TMO-th such edge. Assumes clear arrives in the
// address phase, before run starts.
module pci_rd_devsel_timer #(
    parameter int TMO = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic devsel_i,
    output logic expire
);
    localparam int CNT_W = $clog2(TMO + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TMO - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             seen_q;

    // Track whether the target has claimed and how long it has not.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (run) begin
            if (devsel_i)
                seen_q <= 1'b1;
            else if (!seen_q && cnt_q != LIMIT)
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Expiry: last allowed edge passes with no claim.
    always_comb expire = run && !seen_q && !devsel_i && (cnt_q == LIMIT);
endmodule

// File: rtl/pci_rd_capture.sv
// Read-data capture. Registers the AD lines on a transfer edge and
// presents them with a one-cycle valid strobe.
module pci_rd_capture #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer,
    input  logic [DW-1:0] ad_i,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data
);
    // Capture a word on each completed beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= xfer;
            if (xfer)
                rsp_data <= ad_i;
        end
    end
endmodule

// File: rtl/pci_rd_master.sv
// PCI read initiator top. Accepts a local request when idle, runs the
// address phase, turnaround and data phases, ends with FRAME negated
// while IRDY is held, and drops IRDY one clock after the final beat.
// Assumes the bus is always granted and IRDY is never throttled locally.
module pci_rd_master
    import pci_rd_pkg::*;
#(
    parameter int AW         = 32,
    parameter int BE_W       = 4,
    parameter int BEAT_W     = 8,
    parameter int DEVSEL_TMO = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic [BE_W-1:0]   req_cmd,
    input  logic [BE_W-1:0]   req_be,
    input  logic [BEAT_W-1:0] req_beats,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [AW-1:0]     rsp_data,
    output logic              done,
    output logic              abort_err,
    output logic              frame_o,
    output logic              irdy_o,
    output logic              ctl_oe,
    output logic [BE_W-1:0]   cbe_o,
    output logic [AW-1:0]     ad_o,
    output logic              ad_oe,
    input  logic [AW-1:0]     ad_i,
    input  logic              trdy_i,
    input  logic              devsel_i
);
    rd_state_e         state_q;
    logic [AW-1:0]     addr_q;
    logic [BE_W-1:0]   cmd_q;
    logic [BE_W-1:0]   be_q;
    logic              abort_q;
    logic              accept;
    logic              xfer;
    logic              last_beat;
    logic              expire;

    // Request handshake and beat transfer detection.
    always_comb begin
        accept = (state_q == ST_IDLE) && req_valid;
        xfer   = (state_q == ST_DATA) && irdy_o && trdy_i;
    end

    // Transaction sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            abort_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_ADDR;
                    abort_q <= 1'b0;
                end
                ST_ADDR: state_q <= ST_DATA;
                ST_DATA: begin
                    if (xfer && last_beat)
                        state_q <= ST_END;
                    else if (expire)
                        state_q <= ST_FLUSH;
                end
                ST_FLUSH: begin
                    state_q <= ST_END;
                    abort_q <= 1'b1;
                end
                ST_END:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Latch request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cmd_q  <= '0;
            be_q   <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            cmd_q  <= req_cmd;
            be_q   <= req_be;
        end
    end

    // Bus-side levels and enables decoded from the phase.
    always_comb begin
        frame_o   = (state_q == ST_ADDR) || (state_q == ST_DATA && !last_beat);
        irdy_o    = (state_q == ST_DATA) || (state_q == ST_FLUSH);
        ctl_oe    = (state_q != ST_IDLE);
        ad_oe     = (state_q == ST_ADDR);
        ad_o      = ad_oe ? addr_q : '0;
        cbe_o     = (state_q == ST_ADDR) ? cmd_q : be_q;
        req_ready = (state_q == ST_IDLE);
        done      = (state_q == ST_END);
        abort_err = (state_q == ST_END) && abort_q;
    end

    pci_rd_beat_ctr #(.BEAT_W(BEAT_W)) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (req_beats),
        .dec      (xfer),
        .last     (last_beat)
    );

    pci_rd_devsel_timer #(.TMO(DEVSEL_TMO)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state_q == ST_ADDR),
        .run      (state_q == ST_DATA),
        .devsel_i (devsel_i),
        .expire   (expire)
    );

    pci_rd_capture #(.DW(AW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer      (xfer),
        .ad_i      (ad_i),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );
endmodule

// File: rtl/pci_rd_master_chk.sv
// Protocol checker for the PCI read initiator, bound to every instance.
module pci_rd_master_chk #(
    parameter int AW   = 32,
    parameter int BE_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            done,
    input logic            abort_err,
    input logic            frame_o,
    input logic            irdy_o,
    input logic            ctl_oe,
    input logic [BE_W-1:0] cbe_o,
    input logic [AW-1:0]   ad_o,
    input logic            ad_oe,
    input logic            trdy_i
);
    // R1: address phase has FRAME up and IRDY down
    p_addr_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (frame_o && !irdy_o && ctl_oe));

    // R2: AD released right after the address phase
    p_turnaround_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |=> !ad_oe);

    // R3: C/BE driven whenever IRDY is
    p_cbe_driven_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irdy_o |-> ctl_oe);

    // R4: returned word traces back to IRDY and TRDY at the previous edge
    p_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(irdy_o && trdy_i));

    // R5: FRAME only falls while IRDY is asserted
    p_frame_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe && $fell(frame_o)) |-> irdy_o);

    // R6: after the final beat IRDY drops and done follows
    p_last_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irdy_o && !frame_o && trdy_i) |=> (!irdy_o && done));

    // R6: idle and ready after completion
    p_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_ready && !ctl_oe));

    // R7: error only alongside done, with no word returned
    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_err |-> (done && !rsp_valid));

    // R8: no bus drive while idle
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ctl_oe && !ad_oe && ad_o == '0 && !done));

    // R3: byte enables stable across the data phases
    p_cbe_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irdy_o && $past(irdy_o)) |-> $stable(cbe_o));
endmodule

bind pci_rd_master pci_rd_master_chk #(.AW(AW), .BE_W(BE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .done      (done),
    .abort_err (abort_err),
    .frame_o   (frame_o),
    .irdy_o    (irdy_o),
    .ctl_oe    (ctl_oe),
    .cbe_o     (cbe_o),
    .ad_o      (ad_o),
    .ad_oe     (ad_oe),
    .trdy_i    (trdy_i)
);

// File: tb/pci_rd_master_test.sv
// Bench: behavioural target and reference model, compared every clock.
module pci_rd_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_cmd = '0;
    logic [3:0]  req_be = '0;
    logic [7:0]  req_beats = '0;
    logic        req_ready, rsp_valid, done, abort_err;
    logic [31:0] rsp_data;
    logic        frame_o, irdy_o, ctl_oe, ad_oe;
    logic [3:0]  cbe_o;
    logic [31:0] ad_o;
    logic        trdy_i = 1'b0, devsel_i = 1'b0;
    logic [31:0] tgt_data = '0;
    logic [31:0] ad_i;

    // Bus resolver: initiator drives AD only when enabled, else the target.
    assign ad_i = ad_oe ? ad_o : tgt_data;

    pci_rd_master uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_cmd(req_cmd), .req_be(req_be), .req_beats(req_beats),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .done(done), .abort_err(abort_err), .frame_o(frame_o), .irdy_o(irdy_o),
        .ctl_oe(ctl_oe), .cbe_o(cbe_o), .ad_o(ad_o), .ad_oe(ad_oe),
        .ad_i(ad_i), .trdy_i(trdy_i), .devsel_i(devsel_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    // Reference model state: 0 idle, 1 addr, 2 data, 3 flush, 4 end.
    int          ph = 0;
    logic [31:0] m_addr;
    logic [3:0]  m_cmd, m_be;
    int          m_rem, m_tmo, m_dk;
    bit          m_seen, m_abort;
    bit          e_rv = 0;
    logic [31:0] e_rd = '0;
    int          words [$];

    task automatic cmp(input string req, input string nm,
                       input logic [31:0] act, input logic [31:0] exp_v);
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, nm, act, exp_v, $time);
        end
    endtask

    task automatic check_outputs();
        vectors++;
        cmp("R8", "req_ready", req_ready, ph == 0);
        cmp("R1", "ad_oe", ad_oe, ph == 1);
        if (ph == 1) begin
            cmp("R1", "ad_o", ad_o, m_addr);
            cmp("R1", "cbe_o cmd", cbe_o, m_cmd);
        end
        cmp("R3", "ctl_oe", ctl_oe, ph != 0);
        if (ph >= 2) cmp("R3", "cbe_o be", cbe_o, m_be);
        cmp("R5", "frame_o", frame_o, (ph == 1) || (ph == 2 && m_rem > 1));
        cmp("R5", "irdy_o", irdy_o, ph == 2 || ph == 3);
        cmp("R6", "done", done, ph == 4);
        cmp("R7", "abort_err", abort_err, ph == 4 && m_abort);
        cmp("R4", "rsp_valid", rsp_valid, e_rv);
        if (e_rv) cmp("R4", "rsp_data", rsp_data, e_rd);
    endtask

    // Advance the model across one rising edge with the driven inputs.
    task automatic model_step();
        bit nrv = 0;
        case (ph)
            0: if (req_valid) begin
                m_addr = req_addr; m_cmd = req_cmd; m_be = req_be;
                m_rem = (req_beats == 0) ? 1 : int'(req_beats);
                m_abort = 0; ph = 1;
            end
            1: begin ph = 2; m_tmo = 0; m_seen = 0; m_dk = 0; end
            2: begin
                if (trdy_i) begin
                    nrv = 1; e_rd = tgt_data; words.push_back(int'(tgt_data));
                    m_rem--;
                    if (m_rem == 0) ph = 4;
                end else if (!m_seen && !devsel_i && m_tmo == TMO - 1) begin
                    ph = 3;
                end
                if (devsel_i) m_seen = 1;
                else if (!m_seen) m_tmo++;
                m_dk++;
            end
            3: begin ph = 4; m_abort = 1; end
            default: ph = 0;
        endcase
        e_rv = nrv;
    endtask

    // Run one transaction against a target with decode delay and waits.
    task automatic run_txn(input logic [31:0] a, input logic [3:0] c,
                           input logic [3:0] be, input logic [7:0] n,
                           input int dsel, input int w0, input int w1,
                           input int w2, input int w3);
        int waits[4];
        int beat = 0;
        int wleft;
        bit started = 0;
        waits[0] = w0; waits[1] = w1; waits[2] = w2; waits[3] = w3;
        wleft = waits[0];
        words.delete();
        while (!(started && ph == 0)) begin
            @(negedge clk);
            check_outputs();
            req_valid = (ph == 0) && !started;
            req_addr = a; req_cmd = c; req_be = be; req_beats = n;
            if (ph == 0 && !started) started = 1;
            devsel_i = 0; trdy_i = 0;
            tgt_data = 32'hD000_0000 + cycles;
            if (ph == 1) trdy_i = 1;          // spurious, IRDY low (R4)
            if (ph == 2) begin
                devsel_i = (m_dk >= dsel);
                if (devsel_i && m_dk >= 1) begin
                    if (wleft == 0) begin
                        trdy_i = 1; beat++; wleft = waits[beat % 4];
                    end else wleft--;
                end
            end
            model_step();
        end
        @(negedge clk);
        check_outputs();
        req_valid = 0; trdy_i = 0; devsel_i = 0;
        model_step();
    endtask

    always @(posedge clk) cycles++;

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        check_outputs();
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs();
        model_step();
        // R1 R5: single beat, fast decode
        run_txn(32'h1000_0040, 4'h6, 4'hF, 8'd1, 0, 0, 0, 0, 0);
        if (words.size() != 1) begin errors++; $display("FAIL R5 beats actual %0d expected 1", words.size()); end
        // R4 R5: four-beat burst with wait cycles
        run_txn(32'h2000_0100, 4'hC, 4'h3, 8'd4, 1, 0, 2, 0, 1);
        if (words.size() != 4) begin errors++; $display("FAIL R4 beats actual %0d expected 4", words.size()); end
        // R2 R3: slow decode, three beats
        run_txn(32'h3000_0000, 4'h6, 4'h5, 8'd3, 2, 1, 0, 3, 0);
        // R7: no target, master abort
        run_txn(32'h4000_0000, 4'h6, 4'hF, 8'd2, 99, 0, 0, 0, 0);
        if (words.size() != 0) begin errors++; $display("FAIL R7 words actual %0d expected 0", words.size()); end
        // R7: claim on the fifth data edge avoids abort
        run_txn(32'h5000_0010, 4'hE, 4'hA, 8'd2, 4, 0, 0, 0, 0);
        if (words.size() != 2) begin errors++; $display("FAIL R7 late claim beats actual %0d expected 2", words.size()); end
        // R9: zero count is one beat
        run_txn(32'h6000_0000, 4'h6, 4'hF, 8'd0, 0, 2, 0, 0, 0);
        if (words.size() != 1) begin errors++; $display("FAIL R9 beats actual %0d expected 1", words.size()); end
        // R6: back-to-back requests
        run_txn(32'h7000_0000, 4'h6, 4'h1, 8'd2, 0, 0, 0, 0, 0);
        run_txn(32'h7000_0008, 4'h6, 4'h2, 8'd1, 1, 0, 0, 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule